// File: doc/BRIEF.md
# Cache Storage Data-Space Window Translator

This block lets software reach the instruction cache storage as ordinary data memory. A 4K-location window in data space sits at a programmable logical base. While the cache is held in data mode, any access whose upper address bits equal that base is claimed. The 12-bit offset inside the window is then decoded into a strobe for one of three storage arrays, or the access is flagged as unavailable. The arrays are the instruction words, the low 16 tag bits, and the byte-wide upper tag and line-state fields. The physical base of the window is always zero. Software uses the window as scratch RAM, or to edit tags, valid bits and lock bits before it returns the cache to code mode.

Addresses are 16-bit word locations. A code word held in line L, slot W lives at offset W*0x200 + L. The tag-low half of line L lives at 0x800 + L. The byte-wide fields live in the 0xA00..0xBFF block and use only the odd (upper) byte lane. Array reads are synchronous, so read data returns one cycle after the request, multiplexed from the array that was addressed.

Top module: `cache_ram_xlat`

## Requirements
- R1: An access is claimed (`match_o`=1) only when `req_i`=1, `data_mode_i`=1 and `addr_i[ADDR_W-1:12]` equals `base_i`. An unclaimed access raises no array strobe and produces no read response.
- R2: While `data_mode_i`=0 the translator claims nothing, even for addresses inside the window.
- R3: Offsets 0x000..0x7FF with (offset & 0x1FF) < LINES select the word array. The index is {offset[10:9], offset[7:0]}, so line 0x8A slot 3 (offset 0x68A) gives index 0x38A. Write data and byte enables pass through unchanged.
- R4: Offsets 0x800..0x9FF with (offset & 0x1FF) < LINES select the tag-low array at index offset[7:0].
- R5: Offsets 0xA00..0xBFF select the byte array at line offset[7:0]. `thi_field_o`=offset[8]: 0 is the upper tag byte, 1 is {3'b0, lock, valid[3:0]}. Only byte lane 1 (`wdata_i[15:8]`) is written, and a read returns {byte, 8'h00}.
- R6: A write into 0xA00..0xBFF with `be_i[1]`=0 raises no strobe, and the stored byte is left unchanged.
- R7: Offsets 0xC00..0xFFF are unavailable. `unavail_o`=1, no strobe is raised, writes are dropped, and reads return 0.
- R8: Offsets in 0x000..0x9FF whose low nine bits are ≥ LINES (0x100..0x1FF, 0x900..0x9FF and similar with LINES=256) are unavailable in the same way as R7.
- R9: A claimed read gives `rvalid_o`=1 exactly one cycle later with the routed data. Writes and unclaimed accesses give no `rvalid_o`.
- R10: Changing `base_i` moves the window. The old range stops matching and the new one reaches the same storage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_mode_i | input | 1 | Cache storage is in data mode |
| base_i | input | ADDR_W-12 | Logical base (upper address bits) of the window |
| req_i | input | 1 | Data access request |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Word address |
| be_i | input | 2 | Byte lane enables (bit 1 = odd/upper byte) |
| wdata_i | input | 16 | Write data |
| match_o | output | 1 | Access claimed by the window |
| unavail_o | output | 1 | Claimed offset has no storage |
| rvalid_o | output | 1 | Read data valid (one cycle after a claimed read) |
| rdata_o | output | 16 | Read data |
| wrd_en_o | output | 1 | Word array strobe |
| wrd_we_o | output | 1 | Word array write |
| wrd_idx_o | output | LINE_W+2 | Word array index {slot, line} |
| wrd_be_o | output | 2 | Word array byte enables |
| wrd_wdata_o | output | 16 | Word array write data |
| wrd_rdata_i | input | 16 | Word array read data (one cycle after strobe) |
| tlo_en_o | output | 1 | Tag-low array strobe |
| tlo_we_o | output | 1 | Tag-low array write |
| tlo_idx_o | output | LINE_W | Tag-low line index |
| tlo_be_o | output | 2 | Tag-low byte enables |
| tlo_wdata_o | output | 16 | Tag-low write data |
| tlo_rdata_i | input | 16 | Tag-low read data |
| thi_en_o | output | 1 | Byte array strobe |
| thi_we_o | output | 1 | Byte array write |
| thi_idx_o | output | LINE_W | Byte array line index |
| thi_field_o | output | 1 | 0 = upper tag byte, 1 = lock/valid byte |
| thi_wdata_o | output | 8 | Byte array write data |
| thi_rdata_i | input | 8 | Byte array read data |

## Verification
The assertions assume that the three storage arrays answer a strobed read on the next clock edge and hold their read data until the next strobe. They also assume that `be_i` and `we_i` are meaningful only while `req_i` is high. The bench models the arrays as synchronous memories that obey that rule. It changes inputs only on the falling edge, so every request is stable across the rising edge at which the arrays and the response register sample it. Read expectations are queued per request and retired only when `rvalid_o` rises. Any response that is not queued is reported as a failure.

// File: rtl/cache_ram_xlat_pkg.sv
package cache_ram_xlat_pkg;
  localparam int WIN_W  = 12;
  localparam int BLK_W  = 9;   // 0x200 locations per block

  typedef enum logic [1:0] {
    RG_NONE = 2'd0,
    RG_WORD = 2'd1,
    RG_TLO  = 2'd2,
    RG_THI  = 2'd3
  } region_e;
endpackage

// File: rtl/xlat_decode.sv
module xlat_decode
  import cache_ram_xlat_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LINES  = 256,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic                    req_i,
  input  logic                    data_mode_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [ADDR_W-WIN_W-1:0] base_i,
  output logic                    in_win_o,
  output region_e                 region_o,
  output logic [LINE_W+1:0]       word_idx_o,
  output logic [LINE_W-1:0]       line_o,
  output logic                    field_o
);
  localparam logic [9:0] LIM = 10'(LINES);

  logic [WIN_W-1:0] off;
  logic [2:0]       blk;
  logic [BLK_W-1:0] sub;
  logic             line_ok, hline_ok;

  assign off      = addr_i[WIN_W-1:0];
  assign blk      = off[11:9];
  assign sub      = off[BLK_W-1:0];
  assign line_ok  = ({1'b0, sub} < LIM);
  assign hline_ok = ({2'b00, off[7:0]} < LIM);

  assign in_win_o   = req_i && data_mode_i && (addr_i[ADDR_W-1:WIN_W] == base_i);
  assign word_idx_o = {blk[1:0], sub[LINE_W-1:0]};
  assign line_o     = off[LINE_W-1:0];
  assign field_o    = off[8];

  always_comb begin
    region_o = RG_NONE;
    unique case (blk)
      3'd0, 3'd1, 3'd2, 3'd3: if (line_ok)  region_o = RG_WORD;
      3'd4:                   if (line_ok)  region_o = RG_TLO;
      3'd5:                   if (hline_ok) region_o = RG_THI;
      default:                region_o = RG_NONE;
    endcase
  end
endmodule

// File: rtl/xlat_rdmux.sv
module xlat_rdmux
  import cache_ram_xlat_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        rd_i,
  input  region_e     region_i,
  input  logic [15:0] wrd_rdata_i,
  input  logic [15:0] tlo_rdata_i,
  input  logic [7:0]  thi_rdata_i,
  output logic        rvalid_o,
  output logic [15:0] rdata_o
);
  region_e sel_q;
  logic    rv_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q  <= 1'b0;
      sel_q <= RG_NONE;
    end else begin
      rv_q <= rd_i;
      if (rd_i) sel_q <= region_i;
    end
  end

  assign rvalid_o = rv_q;

  always_comb begin
    rdata_o = 16'h0000;
    if (rv_q) begin
      unique case (sel_q)
        RG_WORD: rdata_o = wrd_rdata_i;
        RG_TLO:  rdata_o = tlo_rdata_i;
        RG_THI:  rdata_o = {thi_rdata_i, 8'h00};
        default: rdata_o = 16'h0000;
      endcase
    end
  end
endmodule

// File: rtl/cache_ram_xlat.sv
module cache_ram_xlat
  import cache_ram_xlat_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int LINES  = 256,
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    data_mode_i,
  input  logic [ADDR_W-WIN_W-1:0] base_i,
  input  logic                    req_i,
  input  logic                    we_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [1:0]              be_i,
  input  logic [15:0]             wdata_i,
  output logic                    match_o,
  output logic                    unavail_o,
  output logic                    rvalid_o,
  output logic [15:0]             rdata_o,
  output logic                    wrd_en_o,
  output logic                    wrd_we_o,
  output logic [LINE_W+1:0]       wrd_idx_o,
  output logic [1:0]              wrd_be_o,
  output logic [15:0]             wrd_wdata_o,
  input  logic [15:0]             wrd_rdata_i,
  output logic                    tlo_en_o,
  output logic                    tlo_we_o,
  output logic [LINE_W-1:0]       tlo_idx_o,
  output logic [1:0]              tlo_be_o,
  output logic [15:0]             tlo_wdata_o,
  input  logic [15:0]             tlo_rdata_i,
  output logic                    thi_en_o,
  output logic                    thi_we_o,
  output logic [LINE_W-1:0]       thi_idx_o,
  output logic                    thi_field_o,
  output logic [7:0]              thi_wdata_o,
  input  logic [7:0]              thi_rdata_i
);
  logic              in_win;
  region_e           region;
  logic [LINE_W+1:0] word_idx;
  logic [LINE_W-1:0] line;
  logic              field;

  xlat_decode #(.ADDR_W(ADDR_W), .LINES(LINES)) u_dec (
    .req_i       (req_i),
    .data_mode_i (data_mode_i),
    .addr_i      (addr_i),
    .base_i      (base_i),
    .in_win_o    (in_win),
    .region_o    (region),
    .word_idx_o  (word_idx),
    .line_o      (line),
    .field_o     (field)
  );

  assign match_o   = in_win;
  assign unavail_o = in_win && (region == RG_NONE);

  assign wrd_en_o    = in_win && (region == RG_WORD);
  assign wrd_we_o    = we_i;
  assign wrd_idx_o   = word_idx;
  assign wrd_be_o    = be_i;
  assign wrd_wdata_o = wdata_i;

  assign tlo_en_o    = in_win && (region == RG_TLO);
  assign tlo_we_o    = we_i;
  assign tlo_idx_o   = line;
  assign tlo_be_o    = be_i;
  assign tlo_wdata_o = wdata_i;

  // byte array lives on the odd lane only; a write without it is dropped
  assign thi_en_o    = in_win && (region == RG_THI) && (!we_i || be_i[1]);
  assign thi_we_o    = we_i;
  assign thi_idx_o   = line;
  assign thi_field_o = field;
  assign thi_wdata_o = wdata_i[15:8];

  xlat_rdmux u_rdm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rd_i        (in_win && !we_i),
    .region_i    (region),
    .wrd_rdata_i (wrd_rdata_i),
    .tlo_rdata_i (tlo_rdata_i),
    .thi_rdata_i (thi_rdata_i),
    .rvalid_o    (rvalid_o),
    .rdata_o     (rdata_o)
  );
endmodule

// File: rtl/cache_ram_xlat_chk.sv
module cache_ram_xlat_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        data_mode_i,
  input logic        req_i,
  input logic        we_i,
  input logic [1:0]  be_i,
  input logic        match_o,
  input logic        unavail_o,
  input logic        rvalid_o,
  input logic [15:0] rdata_o,
  input logic        wrd_en_o,
  input logic        tlo_en_o,
  input logic        thi_en_o,
  input logic        thi_we_o
);
  logic any_en;
  assign any_en = wrd_en_o || tlo_en_o || thi_en_o;

  a_r1_strobe_needs_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_en |-> match_o && req_i);

  a_r1_one_array: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wrd_en_o, tlo_en_o, thi_en_o}));

  a_r2_idle_in_code_mode: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !data_mode_i |-> !match_o && !any_en);

  a_r6_byte_lane_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thi_en_o && thi_we_o) |-> be_i[1]);

  a_r7_unavail_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unavail_o |-> !any_en);

  a_r7_unavail_reads_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && unavail_o && !we_i) |=> rvalid_o && (rdata_o == 16'h0000));

  a_r9_read_response: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && match_o && !we_i) |=> rvalid_o);

  a_r9_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && match_o && !we_i) |=> !rvalid_o);
endmodule

bind cache_ram_xlat cache_ram_xlat_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .data_mode_i (data_mode_i),
  .req_i       (req_i),
  .we_i        (we_i),
  .be_i        (be_i),
  .match_o     (match_o),
  .unavail_o   (unavail_o),
  .rvalid_o    (rvalid_o),
  .rdata_o     (rdata_o),
  .wrd_en_o    (wrd_en_o),
  .tlo_en_o    (tlo_en_o),
  .thi_en_o    (thi_en_o),
  .thi_we_o    (thi_we_o)
);

// File: tb/cache_ram_xlat_bench.sv
`timescale 1ns/1ps
module cache_ram_xlat_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        data_mode_i = 1'b0;
  logic [11:0] base_i = 12'h123;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [23:0] addr_i = '0;
  logic [1:0]  be_i = 2'b00;
  logic [15:0] wdata_i = '0;
  logic        match_o, unavail_o, rvalid_o;
  logic [15:0] rdata_o;
  logic        wrd_en_o, wrd_we_o, tlo_en_o, tlo_we_o, thi_en_o, thi_we_o, thi_field_o;
  logic [9:0]  wrd_idx_o;
  logic [7:0]  tlo_idx_o, thi_idx_o, thi_wdata_o;
  logic [1:0]  wrd_be_o, tlo_be_o;
  logic [15:0] wrd_wdata_o, tlo_wdata_o;
  logic [15:0] wrd_rdata_i, tlo_rdata_i;
  logic [7:0]  thi_rdata_i;

  always #2.5 clk_i = ~clk_i;

  cache_ram_xlat u_cache_ram_xlat (.*);

  // storage model: synchronous arrays
  logic [15:0] wrd_mem [1024];
  logic [15:0] tlo_mem [256];
  logic [7:0]  thi_mem [512];

  always_ff @(posedge clk_i) begin
    if (wrd_en_o) begin
      if (wrd_we_o) begin
        if (wrd_be_o[0]) wrd_mem[wrd_idx_o][7:0]  <= wrd_wdata_o[7:0];
        if (wrd_be_o[1]) wrd_mem[wrd_idx_o][15:8] <= wrd_wdata_o[15:8];
      end else wrd_rdata_i <= wrd_mem[wrd_idx_o];
    end
    if (tlo_en_o) begin
      if (tlo_we_o) begin
        if (tlo_be_o[0]) tlo_mem[tlo_idx_o][7:0]  <= tlo_wdata_o[7:0];
        if (tlo_be_o[1]) tlo_mem[tlo_idx_o][15:8] <= tlo_wdata_o[15:8];
      end else tlo_rdata_i <= tlo_mem[tlo_idx_o];
    end
    if (thi_en_o) begin
      if (thi_we_o) thi_mem[{thi_field_o, thi_idx_o}] <= thi_wdata_o;
      else          thi_rdata_i <= thi_mem[{thi_field_o, thi_idx_o}];
    end
  end

  int n_run = 0;
  int n_fail = 0;
  logic [15:0] exp_q [$];
  string       tag_q [$];

  task automatic chk(input logic ok, input string rq, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // port: 0 none, 1 word, 2 tag-low, 3 byte array; idx[8] = field for byte array
  task automatic acc(input logic [23:0] a, input logic w, input logic [1:0] be,
                     input logic [15:0] d, input logic em, input logic eu,
                     input int port, input logic [9:0] eidx,
                     input logic [15:0] erd, input string rq);
    logic [2:0] exp_en;
    @(negedge clk_i);
    req_i = 1'b1; we_i = w; addr_i = a; be_i = be; wdata_i = d;
    #1;
    chk(match_o == em, {rq, " match"}, 16'(match_o), 16'(em));
    chk(unavail_o == eu, {rq, " unavail"}, 16'(unavail_o), 16'(eu));
    exp_en = (port == 1) ? 3'b100 : (port == 2) ? 3'b010 : (port == 3) ? 3'b001 : 3'b000;
    chk({wrd_en_o, tlo_en_o, thi_en_o} == exp_en, {rq, " strobe"},
        16'({wrd_en_o, tlo_en_o, thi_en_o}), 16'(exp_en));
    if (port == 1) chk(wrd_idx_o == eidx, {rq, " word index"}, 16'(wrd_idx_o), 16'(eidx));
    if (port == 2) chk(tlo_idx_o == eidx[7:0], {rq, " tlo index"}, 16'(tlo_idx_o), 16'(eidx[7:0]));
    if (port == 3) begin
      chk({thi_field_o, thi_idx_o} == eidx[8:0], {rq, " byte index"},
          16'({thi_field_o, thi_idx_o}), 16'(eidx[8:0]));
      if (w) chk(thi_wdata_o == d[15:8], {rq, " byte wdata"}, 16'(thi_wdata_o), 16'(d[15:8]));
    end
    if (em && !w) begin
      exp_q.push_back(erd);
      tag_q.push_back(rq);
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    req_i = 1'b0; we_i = 1'b0; be_i = 2'b00;
  endtask

  // monitor: retire queued reads on rvalid
  always @(negedge clk_i) begin
    if (rst_ni && rvalid_o) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected rvalid", rdata_o, 16'h0000);
      else begin
        automatic logic [15:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rdata_o == e, {t, " rdata"}, rdata_o, e);
      end
    end
  end

  logic done = 1'b0;
  initial begin
    #(5.0 * 20000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(rvalid_o == 1'b0, "reset rvalid", 16'(rvalid_o), 16'h0);
    chk(match_o == 1'b0, "reset match", 16'(match_o), 16'h0);
    rst_ni = 1'b1;
    data_mode_i = 1'b1;

    // R3: word array writes
    acc(24'h12368A, 1, 2'b11, 16'hBEEF, 1, 0, 1, 10'h38A, 0, "R3 w3 l8a");
    acc(24'h123000, 1, 2'b11, 16'h1111, 1, 0, 1, 10'h000, 0, "R3 w0 l00");
    acc(24'h1232FF, 1, 2'b11, 16'h2222, 1, 0, 1, 10'h1FF, 0, "R3 w1 lff");
    acc(24'h123410, 1, 2'b11, 16'h3333, 1, 0, 1, 10'h210, 0, "R3 w2 l10");
    // R4: tag-low
    acc(24'h12388A, 1, 2'b11, 16'hCAFE, 1, 0, 2, 10'h08A, 0, "R4 tlo l8a");
    // R5: byte array, upper tag and lock/valid fields
    acc(24'h123A8A, 1, 2'b10, 16'h5A00, 1, 0, 3, 10'h08A, 0, "R5 tag byte");
    acc(24'h123B8A, 1, 2'b10, 16'h1F00, 1, 0, 3, 10'h18A, 0, "R5 lock valid");
    // R6: lane-0-only write to byte array is dropped
    acc(24'h123A8A, 1, 2'b01, 16'h00FF, 1, 0, 0, 10'h000, 0, "R6 lane0 write");
    // R7 / R8: unavailable writes
    acc(24'h123C00, 1, 2'b11, 16'hDEAD, 1, 1, 0, 10'h000, 0, "R7 write c00");
    acc(24'h123100, 1, 2'b11, 16'hDEAD, 1, 1, 0, 10'h000, 0, "R8 write gap");

    // back-to-back reads
    acc(24'h12368A, 0, 2'b11, 16'h0, 1, 0, 1, 10'h38A, 16'hBEEF, "R3 read w3");
    acc(24'h123000, 0, 2'b11, 16'h0, 1, 0, 1, 10'h000, 16'h1111, "R3 read w0");
    acc(24'h1232FF, 0, 2'b11, 16'h0, 1, 0, 1, 10'h1FF, 16'h2222, "R3 read w1");
    acc(24'h123410, 0, 2'b11, 16'h0, 1, 0, 1, 10'h210, 16'h3333, "R3 read w2");
    acc(24'h12388A, 0, 2'b11, 16'h0, 1, 0, 2, 10'h08A, 16'hCAFE, "R4 read tlo");
    acc(24'h123A8A, 0, 2'b11, 16'h0, 1, 0, 3, 10'h08A, 16'h5A00, "R6 read back tag");
    acc(24'h123B8A, 0, 2'b11, 16'h0, 1, 0, 3, 10'h18A, 16'h1F00, "R5 read lock valid");
    acc(24'h123FFF, 0, 2'b11, 16'h0, 1, 1, 0, 10'h000, 16'h0000, "R7 read fff");
    acc(24'h123900, 0, 2'b11, 16'h0, 1, 1, 0, 10'h000, 16'h0000, "R8 read 900");
    acc(24'h1237FF, 0, 2'b11, 16'h0, 1, 1, 0, 10'h000, 16'h0000, "R8 read 7ff");
    // R1: outside window
    acc(24'h124000, 0, 2'b11, 16'h0, 0, 0, 0, 10'h000, 0, "R1 outside");
    acc(24'h12268A, 1, 2'b11, 16'h7777, 0, 0, 0, 10'h000, 0, "R1 outside write");
    idle();
    // R2: code mode
    data_mode_i = 1'b0;
    acc(24'h12368A, 0, 2'b11, 16'h0, 0, 0, 0, 10'h000, 0, "R2 code mode read");
    acc(24'h12368A, 1, 2'b11, 16'h9999, 0, 0, 0, 10'h000, 0, "R2 code mode write");
    idle();
    data_mode_i = 1'b1;
    // R10: move base
    base_i = 12'h400;
    acc(24'h12368A, 0, 2'b11, 16'h0, 0, 0, 0, 10'h000, 0, "R10 old base");
    acc(24'h40068A, 0, 2'b11, 16'h0, 1, 0, 1, 10'h38A, 16'hBEEF, "R10 new base");
    acc(24'h400000, 0, 2'b11, 16'h0, 1, 0, 1, 10'h000, 16'h1111, "R10 new base w0");
    idle();
    repeat (3) @(negedge clk_i);
    chk(exp_q.size() == 0, "R9 responses outstanding", 16'(exp_q.size()), 16'h0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule